// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

The block serves 32-bit reads from a memory window backed by a serial flash. A bus read names a byte offset and a chip select. The engine lowers that one chip-select line and shifts out a read opcode, then the address and a run of dummy bytes. It then collects four data bytes over one, two or four data lines. It returns them as one word with a single-cycle ready pulse. Each chip select has its own setup word, which gives the opcode, the address length, the dummy length and the data-line count. A mode switch word decides whether the pins belong to this engine or to the command engine, which lies outside this block.

The serial clock runs at half the system clock, in mode 0 (it idles low). Outgoing bits change while the serial clock is low. Incoming bits are sampled at the system clock edge that ends each high phase of the serial clock. A read that arrives while memory-mapped mode is off is answered at once, with an error flag and zero data, and causes no serial activity.

Top module: `fmr_top`

## Requirements
- R1: After reset all chip-select outputs are high, the serial clock is low, no data line is driven, rd_ready and rd_err are 0, and memory-mapped mode is off.
- R2: A write to byte offset 0x54 + 4*i loads the setup of chip select i, with these fields: [7:0] read opcode, [9:8] address bytes minus one, [11:10] dummy byte count, and [13:12] data lines. In the data-lines field, code 3 selects four lines, code 1 selects two lines, and codes 0 and 2 select one line.
- R3: A write to offset 0x64 sets memory-mapped mode to bit 0 of the write data. A chip select only falls while this mode is on.
- R4: The header goes out on io[0], with io_oe[0]=1, most significant bit first. It consists of the opcode, then the low (address bytes) bytes of rd_off with the most significant byte first, then zero-valued dummy bytes. The serial clock gives one rising edge per header bit.
- R5: The data phase drives no line and takes 32 bits. With one line each bit is on io[1]. With two lines, io[1] carries the earlier bit and io[0] the later one. With four lines, io[3] carries the earliest bit and io[0] the latest.
- R6: The first data byte received appears in rd_data[7:0] and the fourth in rd_data[31:24]. rd_ready is high for exactly one cycle, with rd_err=0.
- R7: Call the edge that accepts rd_req edge 0. rd_ready is high right after edge 2*(H+D), where H = 8*(2+address bytes minus one+dummy count) and D = 32 divided by the number of data lines.
- R8: For the whole transfer, only the chip select named by cs_sel at acceptance is low.
- R9: A read while memory-mapped mode is off gives rd_ready and rd_err high right after the accepting edge, with rd_data=0 and no serial clock or chip-select activity.
- R10: A request that arrives while a transfer is running is ignored. It produces no second rd_ready and does not change the result.
- R11: A setup write in the same cycle that a read is accepted takes effect from the next read. The accepted read uses the previous setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 14 | Configuration write data |
| rd_req | input | 1 | Read request, taken when the engine is idle |
| rd_off | input | OFF_W | Byte offset inside the window |
| cs_sel | input | $clog2(NUM_CS) | Chip select to use |
| rd_data | output | 32 | Read word, valid with rd_ready |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Read refused because mode is off |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_out | output | 4 | Serial data lines out |
| spi_io_oe | output | 4 | Output enables for the data lines |
| spi_io_in | input | 4 | Serial data lines in |

## Verification
Two events can fall on the same clock edge: a setup write to the very chip select being read, and the acceptance of that read. The bench drives both on one edge, giving the write a new opcode. It expects data generated with the old opcode, and then data with the new opcode on the following read. The flash model derives each byte from the opcode and address that it actually received, so the returned word shows which setup was used. A second request sent partway through a transfer must leave both the word and the single ready pulse unchanged.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    localparam int SETUP_W = 14;
    localparam int HDR_W   = 64;
    localparam int WORD_W  = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_DONE
    } fmr_state_e;

    // lanes holds log2 of the data line count: 0, 1 or 2
    typedef struct packed {
        logic [1:0] lanes;
        logic [1:0] dummy;
        logic [1:0] aw;
        logic [7:0] op;
    } setup_t;

    function automatic setup_t decode_setup(input logic [SETUP_W-1:0] raw);
        setup_t s;
        s.op    = raw[7:0];
        s.aw    = raw[9:8];
        s.dummy = raw[11:10];
        unique case (raw[13:12])
            2'b11:   s.lanes = 2'd2;
            2'b01:   s.lanes = 2'd1;
            default: s.lanes = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fmr_cfg.sv
module fmr_cfg
    import fmr_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int CFG_AW     = 8,
    parameter int SETUP_BASE = 'h54,
    parameter int SWITCH_OFF = 'h64,
    localparam int CS_W      = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic [CS_W-1:0]    cs_sel,
    output setup_t             sel_setup,
    output logic               mm_en
);

    typedef struct packed {
        setup_t [NUM_CS-1:0] setup;
        logic                mm_en;
    } cfg_t;

    cfg_t q, d;
    logic [NUM_CS-1:0] slot_hit;
    logic              switch_hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
        assign slot_hit[i] = cfg_we && (cfg_addr == CFG_AW'(SETUP_BASE + 4 * i));
    end

    assign switch_hit = cfg_we && (cfg_addr == CFG_AW'(SWITCH_OFF));

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (slot_hit[i]) begin
                d.setup[i] = decode_setup(cfg_wdata);
            end
        end
        if (switch_hit) begin
            d.mm_en = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel_setup = q.setup[cs_sel];
    assign mm_en     = q.mm_en;

endmodule

// File: rtl/fmr_seq.sv
module fmr_seq
    import fmr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int OFF_W  = 24,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [OFF_W-1:0] rd_off,
    input  logic [CS_W-1:0]  cs_sel,
    input  logic             mm_en,
    input  setup_t           sel_setup,
    output logic             sclk,
    output logic             cs_act,
    output logic [CS_W-1:0]  cs_idx,
    output logic             mosi,
    output logic             mosi_oe,
    output logic             cap_stb,
    output logic             cap_clr,
    output logic [1:0]       lanes,
    output logic             rd_ready,
    output logic             rd_err
);

    typedef struct packed {
        fmr_state_e       state;
        logic             sclk;
        logic [HDR_W-1:0] hdr;
        logic [6:0]       hcnt;
        logic [5:0]       dcnt;
        logic [CS_W-1:0]  cs;
        logic [1:0]       lanes;
        logic             ready;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic [31:0] addr32;
    logic [31:0] addr_al;
    logic [6:0]  hbits;

    // left-align the used address bytes so they leave first
    assign addr32  = 32'(rd_off);
    assign addr_al = addr32 << {(2'd3 - sel_setup.aw), 3'b000};
    assign hbits   = 7'({5'd0, sel_setup.aw} + 7'd2 + {5'd0, sel_setup.dummy}) << 3;

    always_comb begin
        d       = q;
        d.ready = 1'b0;
        d.err   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (rd_req) begin
                    if (mm_en) begin
                        d.state = ST_HDR;
                        d.sclk  = 1'b0;
                        d.cs    = cs_sel;
                        d.lanes = sel_setup.lanes;
                        d.hdr   = {sel_setup.op, addr_al, 24'h0};
                        d.hcnt  = hbits;
                        d.dcnt  = 6'd32 >> sel_setup.lanes;
                    end else begin
                        d.state = ST_DONE;
                        d.ready = 1'b1;
                        d.err   = 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    d.hdr  = {q.hdr[HDR_W-2:0], 1'b0};
                    if (q.hcnt == 7'd1) begin
                        d.state = ST_DATA;
                    end else begin
                        d.hcnt = q.hcnt - 7'd1;
                    end
                end
            end
            ST_DATA: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    if (q.dcnt == 6'd1) begin
                        d.state = ST_DONE;
                        d.ready = 1'b1;
                    end else begin
                        d.dcnt = q.dcnt - 6'd1;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk     = q.sclk;
    assign cs_act   = (q.state == ST_HDR) || (q.state == ST_DATA);
    assign cs_idx   = q.cs;
    assign mosi_oe  = (q.state == ST_HDR);
    assign mosi     = (q.state == ST_HDR) && q.hdr[HDR_W-1];
    assign cap_stb  = (q.state == ST_DATA) && q.sclk;
    assign cap_clr  = (q.state == ST_IDLE) && rd_req;
    assign lanes    = q.lanes;
    assign rd_ready = q.ready;
    assign rd_err   = q.err;

    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready)
        else $error("rd_ready held longer than one cycle");

    a_r3_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HDR && $past(q.state) == ST_IDLE) |-> $past(mm_en))
        else $error("transfer started while memory-mapped mode off");

    a_r10_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && ($past(q.state) == ST_HDR || $past(q.state) == ST_DATA)) |-> $stable(q.cs))
        else $error("chip select changed mid transfer");

endmodule

// File: rtl/fmr_cap.sv
module fmr_cap
    import fmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [1:0]        lanes,
    input  logic [3:0]        io_in,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.sr = '0;
        end else if (stb) begin
            unique case (lanes)
                2'd2:    d.sr = {q.sr[WORD_W-5:0], io_in};
                2'd1:    d.sr = {q.sr[WORD_W-3:0], io_in[1:0]};
                default: d.sr = {q.sr[WORD_W-2:0], io_in[1]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // first received byte sits at the top of the shifter, place it lowest
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
        assign word[8*b +: 8] = q.sr[8*(WORD_BYTES-1-b) +: 8];
    end

endmodule

// File: rtl/fmr_top.sv
module fmr_top
    import fmr_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int OFF_W  = 24,
    parameter int CFG_AW = 8,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic               rd_req,
    input  logic [OFF_W-1:0]   rd_off,
    input  logic [CS_W-1:0]    cs_sel,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_ready,
    output logic               rd_err,
    output logic               spi_sclk,
    output logic [NUM_CS-1:0]  spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in
);

    setup_t          sel_setup;
    logic            mm_en;
    logic            cs_act;
    logic [CS_W-1:0] cs_idx;
    logic            mosi;
    logic            mosi_oe;
    logic            cap_stb;
    logic            cap_clr;
    logic [1:0]      lanes;

    fmr_cfg #(
        .NUM_CS (NUM_CS),
        .CFG_AW (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cs_sel    (cs_sel),
        .sel_setup (sel_setup),
        .mm_en     (mm_en)
    );

    fmr_seq #(
        .NUM_CS (NUM_CS),
        .OFF_W  (OFF_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_off    (rd_off),
        .cs_sel    (cs_sel),
        .mm_en     (mm_en),
        .sel_setup (sel_setup),
        .sclk      (spi_sclk),
        .cs_act    (cs_act),
        .cs_idx    (cs_idx),
        .mosi      (mosi),
        .mosi_oe   (mosi_oe),
        .cap_stb   (cap_stb),
        .cap_clr   (cap_clr),
        .lanes     (lanes),
        .rd_ready  (rd_ready),
        .rd_err    (rd_err)
    );

    fmr_cap u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap_clr),
        .stb   (cap_stb),
        .lanes (lanes),
        .io_in (spi_io_in),
        .word  (rd_data)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
        assign spi_cs_n[i] = !(cs_act && (cs_idx == CS_W'(i)));
    end

    assign spi_io_out = {3'b000, mosi};
    assign spi_io_oe  = {3'b000, mosi_oe};

    a_r8_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n))
        else $error("more than one chip select low");

    a_r4_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_io_oe != 4'b0000) |-> !(&spi_cs_n))
        else $error("data line driven with no chip select");

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (&spi_cs_n && !spi_sclk && rd_data == '0))
        else $error("refused read touched the pins or data");

    a_r3_cs_fall_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&spi_cs_n) |-> $past(mm_en))
        else $error("chip select fell with mode off");

endmodule

// File: tb/fmr_top_tb_top.sv
`timescale 1ns/1ps
module fmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        rd_req = 1'b0;
    logic [23:0] rd_off = '0;
    logic [1:0]  cs_sel = '0;
    logic [31:0] rd_data;
    logic        rd_ready;
    logic        rd_err;
    logic        spi_sclk;
    logic [3:0]  spi_cs_n;
    logic [3:0]  spi_io_out;
    logic [3:0]  spi_io_oe;
    logic [3:0]  tb_io = 4'hF;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fmr_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .rd_req     (rd_req),
        .rd_off     (rd_off),
        .cs_sel     (cs_sel),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready),
        .rd_err     (rd_err),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe),
        .spi_io_in  (tb_io)
    );

    // bench copy of the configuration
    logic [7:0] tb_op [4];
    int         tb_aw [4];
    int         tb_dm [4];
    int         tb_ln [4];
    bit         tb_en;

    // flash model state
    int          cur_h;
    int          cur_aw;
    int          cur_ln;
    int          fl_hcnt;
    int          fl_dcnt;
    logic [63:0] fl_sr;
    logic [63:0] fl_hdr;
    logic [31:0] fl_ad;
    logic [7:0]  fl_op;
    logic [31:0] fl_stream;
    int          rise_cnt;
    logic [3:0]  seen_cs;

    function automatic logic [7:0] fb(input logic [31:0] a, input logic [7:0] op);
        return 8'(a[7:0] * 8'd29 + a[15:8] * 8'd7 + a[23:16] + a[31:24] + op);
    endfunction

    always @(posedge spi_sclk) begin
        rise_cnt = rise_cnt + 1;
        if (spi_io_oe[0]) begin
            fl_sr   = {fl_sr[62:0], spi_io_out[0]};
            fl_hcnt = fl_hcnt + 1;
        end
    end

    always @(negedge spi_sclk) begin
        #1;
        if (fl_hcnt == cur_h) begin
            if (fl_dcnt == 0) begin
                fl_hdr    = fl_sr << (64 - cur_h);
                fl_op     = fl_hdr[63:56];
                fl_ad     = fl_hdr[55:24] >> (8 * (3 - cur_aw));
                fl_stream = {fb(fl_ad, fl_op), fb(fl_ad + 1, fl_op),
                             fb(fl_ad + 2, fl_op), fb(fl_ad + 3, fl_op)};
            end
            case (cur_ln)
                2: begin tb_io = fl_stream[31:28]; fl_stream = fl_stream << 4; end
                1: begin tb_io = {2'b11, fl_stream[31:30]}; fl_stream = fl_stream << 2; end
                default: begin tb_io = {2'b11, fl_stream[31], 1'b1}; fl_stream = fl_stream << 1; end
            endcase
            fl_dcnt = fl_dcnt + 1;
        end
    end

    always @(negedge clk) begin
        seen_cs = seen_cs | ~spi_cs_n;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [13:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int lanes_of(input logic [1:0] raw);
        return (raw == 2'b11) ? 2 : (raw == 2'b01) ? 1 : 0;
    endfunction

    function automatic logic [13:0] pack_setup(input logic [7:0] op, input int aw, input int dm, input logic [1:0] ln);
        return {ln, 2'(dm), 2'(aw), op};
    endfunction

    task automatic set_setup(input int cs, input logic [7:0] op, input int aw, input int dm, input logic [1:0] ln);
        cfg_write(8'(8'h54 + 4 * cs), pack_setup(op, aw, dm, ln));
        tb_op[cs] = op; tb_aw[cs] = aw; tb_dm[cs] = dm; tb_ln[cs] = lanes_of(ln);
    endtask

    task automatic do_read(input int cs, input logic [23:0] off, input bit poke,
                           input bit same_wr, input logic [13:0] new_setup);
        int d;
        int n;
        int exp_n;
        logic [31:0] a;
        logic [31:0] msk;
        logic [31:0] expw;
        cur_h  = 8 + 8 * (tb_aw[cs] + 1) + 8 * tb_dm[cs];
        cur_aw = tb_aw[cs];
        cur_ln = tb_ln[cs];
        d      = 32 >> tb_ln[cs];
        msk    = (tb_aw[cs] == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (tb_aw[cs] + 1))) - 1);
        a      = {8'h00, off} & msk;
        expw   = tb_en ? {fb(a + 3, tb_op[cs]), fb(a + 2, tb_op[cs]), fb(a + 1, tb_op[cs]), fb(a, tb_op[cs])} : 32'h0;
        exp_n  = tb_en ? 2 * (cur_h + d) + 1 : 1;
        @(negedge clk);
        fl_hcnt = 0; fl_dcnt = 0; rise_cnt = 0; seen_cs = 4'h0;
        rd_req = 1'b1; rd_off = off; cs_sel = 2'(cs);
        if (same_wr) begin
            cfg_we = 1'b1; cfg_addr = 8'(8'h54 + 4 * cs); cfg_wdata = new_setup;
        end
        @(negedge clk);
        rd_req = 1'b0; cfg_we = 1'b0;
        n = 1;
        while (!rd_ready && n < 1000) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin rd_req = 1'b1; rd_off = off ^ 24'h5A5A5A; end
            if (poke && n == 11) rd_req = 1'b0;
        end
        check(rd_ready == 1'b1 && n == exp_n, "R7 ready timing", 32'(n), 32'(exp_n));
        check(rd_data == expw, "R6 read word (R2 R4 R5 fields, lanes, order)", rd_data, expw);
        check(rd_err == !tb_en, tb_en ? "R6 error flag clear" : "R9 error flag set", 32'(rd_err), 32'(!tb_en));
        check(seen_cs == (tb_en ? 4'(1 << cs) : 4'h0), tb_en ? "R8 chip select" : "R9 no chip select", 32'(seen_cs), tb_en ? 32'(1 << cs) : 0);
        check(rise_cnt == (tb_en ? cur_h + d : 0), tb_en ? "R4 serial clock edges" : "R9 no serial clock", 32'(rise_cnt), tb_en ? 32'(cur_h + d) : 0);
        @(negedge clk);
        check(rd_ready == 1'b0, "R6 ready single pulse", 32'(rd_ready), 0);
        if (same_wr) begin
            tb_op[cs] = new_setup[7:0]; tb_aw[cs] = int'(new_setup[9:8]);
            tb_dm[cs] = int'(new_setup[11:10]); tb_ln[cs] = lanes_of(new_setup[13:12]);
        end
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check(rd_ready == 1'b0 && (&spi_cs_n), "R10 busy request ignored", {rd_ready, spi_cs_n}, 32'h0F);
            end
        end
    endtask

    initial begin
        #900_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            tb_op[i] = 8'h00; tb_aw[i] = 0; tb_dm[i] = 0; tb_ln[i] = 0;
        end
        tb_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n == 4'hF, "R1 chip selects high", 32'(spi_cs_n), 32'hF);
        check(spi_sclk == 1'b0, "R1 serial clock low", 32'(spi_sclk), 0);
        check(spi_io_oe == 4'h0, "R1 no line driven", 32'(spi_io_oe), 0);
        check(rd_ready == 1'b0 && rd_err == 1'b0, "R1 ready and error low", {rd_ready, rd_err}, 0);

        // mode off after reset: refused
        do_read(0, 24'h001234, 1'b0, 1'b0, '0);

        cfg_write(8'h64, 14'h0001);
        tb_en = 1'b1;
        set_setup(0, 8'h0B, 2, 1, 2'b00);
        set_setup(1, 8'h3B, 3, 1, 2'b01);
        set_setup(2, 8'h6B, 2, 3, 2'b11);
        set_setup(3, 8'h03, 0, 0, 2'b10);
        do_read(0, 24'hABCDEF, 1'b0, 1'b0, '0);
        do_read(1, 24'h123456, 1'b0, 1'b0, '0);
        do_read(2, 24'hFFFFFE, 1'b0, 1'b0, '0);
        do_read(3, 24'h00FF80, 1'b0, 1'b0, '0);

        // R10: extra request mid transfer
        do_read(2, 24'h0A0B0C, 1'b1, 1'b0, '0);

        // R11: setup write on the accepting edge
        do_read(1, 24'h777777, 1'b0, 1'b1, pack_setup(8'hE7, 1, 2, 2'b11));
        do_read(1, 24'h777777, 1'b0, 1'b0, '0);

        for (int it = 0; it < 30; it++) begin
            int cs;
            cs = int'($urandom_range(3, 0));
            if ($urandom_range(1, 0) == 1) begin
                set_setup(cs, 8'($urandom), int'($urandom_range(3, 0)),
                          int'($urandom_range(3, 0)), 2'($urandom_range(3, 0)));
            end
            do_read(cs, 24'($urandom), 1'b0, 1'b0, '0);
        end

        // R3: mode off again refuses
        cfg_write(8'h64, 14'h0000);
        tb_en = 1'b0;
        do_read(2, 24'h000100, 1'b0, 1'b0, '0);
        cfg_write(8'h64, 14'h0001);
        tb_en = 1'b1;
        do_read(0, 24'h000100, 1'b0, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule